// File: doc/BRIEF.md
# Speculative Output Allocator with Recirculation Priority

This block is the switch-side allocation and buffer control for an N-port switch. Sources send packets speculatively, without first asking for a path. Every cycle the block sees two kinds of request. New packets come straight from the sources, each carrying a destination and a tag. Older packets are waiting at the head of the per-source recirculation buffers. The source of every packet is fixed by the port it arrives on, so the block only arbitrates per output. Each output port has its own round-robin arbiter, and each output grants at most one source per cycle.

A new packet that does not get its output is never dropped. It is written into the recirculation buffer that belongs to its source port, and it competes again in a later cycle. Buffered packets always beat new packets. While a source's buffer holds anything, new packets from that source go straight into the buffer, so every source's packets leave in the order they were sent. Each buffer raises a full flag to its source one entry early, which leaves room for one packet already in flight. The payload path and the optical fabric are outside this block. The block carries only the destination and a tag for each packet.

Top module: `spec_out_alloc`

## Requirements
- R1: Each output grants at most one source per cycle. It grants only a source whose active request targets that output, and no source is granted on more than one output. A grant drives `grantValid[o]` together with the source index in `grantSrc[o*IDX_W +: IDX_W]` and the packet tag in `grantTag`.
- R2: Each output keeps a round-robin pointer that is 0 after reset. The search starts at the pointer and rises through the source indices, wrapping at NPORTS. After a grant to source s the pointer becomes s+1 modulo NPORTS. In a cycle without a grant the pointer does not move.
- R3: If any buffer head targets an output, that output grants a buffered request and sets `grantFromBuf[o]`, whatever its pointer says. In that cycle new requests for the output are not considered.
- R4: A new packet that is not granted in its arrival cycle is stored in the buffer of its own source port. It is later granted from that buffer with the same tag and destination, and a granted buffer head is removed.
- R5: A new packet from a source whose buffer is not empty is stored in that buffer, even when its output port is idle in that cycle.
- R6: The grants for any one source carry that source's tags in the order the packets were sent.
- R7: Each buffer holds DEPTH packets (4 by default). `fullFlag[i]` is high exactly when buffer i holds DEPTH-1 or more packets.
- R8: After reset all buffers are empty, every `fullFlag` is low, and no output grants until a request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| newValid | input | NPORTS | A new speculative packet arrives from source i |
| newDest | input | NPORTS*IDX_W | Destination output of each new packet, source i at bits i*IDX_W |
| newTag | input | NPORTS*TAG_W | Tag of each new packet, source i at bits i*TAG_W |
| fullFlag | output | NPORTS | Buffer of source i holds DEPTH-1 or more packets |
| grantValid | output | NPORTS | Output o grants a packet this cycle |
| grantSrc | output | NPORTS*IDX_W | Source index granted on output o |
| grantFromBuf | output | NPORTS | The grant on output o is served from a buffer |
| grantTag | output | NPORTS*TAG_W | Tag of the packet granted on output o |

## Verification
The overflow check assumes that each source reacts to its full flag with no more than one cycle of lag. A source may therefore send at most one packet after the flag rises. The stimulus models this by deciding each cycle's sends from the flags it sampled in the previous cycle. The incast phase keeps the buffers pinned at that limit for many cycles. Destinations are always legal output indices, because the port count is a power of two. Tags only need to be unique among the packets a single source has outstanding, and a per-source counter wider than the buffer depth guarantees that.

// File: rtl/spec_alloc_pkg.sv
package spec_alloc_pkg;
  // Per-source buffer strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } bufStrobe_t;
endpackage

// File: rtl/spec_rr_arb.sv
module spec_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gntIdx,
  output logic          gntAny
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt    = '0;
    gntIdx = '0;
    gntAny = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (int'(ptr) + k) % N;
      if (!gntAny && req[j]) begin
        gnt[j] = 1'b1;
        gntIdx = IW'(j);
        gntAny = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptr <= '0;
    else if (gntAny) ptr <= (gntIdx == IW'(N - 1)) ? '0 : gntIdx + 1'b1;
  end

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (gnt & ~req) == '0);  // R1
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (req == '0) |=> $stable(ptr));  // R2
endmodule

// File: rtl/spec_alloc_buf.sv
module spec_alloc_buf
  import spec_alloc_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  localparam int ENT_W = IDX_W + TAG_W,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bufStrobe_t [NPORTS-1:0]   strobes,
  input  logic [NPORTS*IDX_W-1:0]   newDest,
  input  logic [NPORTS*TAG_W-1:0]   newTag,
  output logic [NPORTS*IDX_W-1:0]   headDest,
  output logic [NPORTS*TAG_W-1:0]   headTag,
  output logic [NPORTS-1:0]         bufEmpty,
  output logic [NPORTS-1:0]         fullFlag
);
  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < NPORTS; g++) begin : gSrc
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PW-1:0]    rdPtr, wrPtr;
    logic [CW-1:0]    count;

    always_ff @(posedge clk) begin
      if (strobes[g].push)
        mem[wrPtr] <= {newDest[g*IDX_W +: IDX_W], newTag[g*TAG_W +: TAG_W]};
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdPtr <= '0;
        wrPtr <= '0;
        count <= '0;
      end else begin
        if (strobes[g].push) wrPtr <= nextPtr(wrPtr);
        if (strobes[g].pop)  rdPtr <= nextPtr(rdPtr);
        unique case ({strobes[g].push, strobes[g].pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: ;
        endcase
      end
    end

    assign headDest[g*IDX_W +: IDX_W] = mem[rdPtr][ENT_W-1 -: IDX_W];
    assign headTag[g*TAG_W +: TAG_W]  = mem[rdPtr][TAG_W-1:0];
    assign bufEmpty[g] = (count == '0);
    assign fullFlag[g] = (count >= CW'(DEPTH - 1));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[g].push && !strobes[g].pop) |-> (count != CW'(DEPTH)));  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      strobes[g].pop |-> (count != '0));  // R4
  end
endmodule

// File: rtl/spec_alloc_ctrl.sv
module spec_alloc_ctrl
  import spec_alloc_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NPORTS-1:0]         newValid,
  input  logic [NPORTS*IDX_W-1:0]   newDest,
  input  logic [NPORTS*TAG_W-1:0]   newTag,
  input  logic [NPORTS*IDX_W-1:0]   headDest,
  input  logic [NPORTS*TAG_W-1:0]   headTag,
  input  logic [NPORTS-1:0]         bufEmpty,
  output bufStrobe_t [NPORTS-1:0]   strobes,
  output logic [NPORTS-1:0]         grantValid,
  output logic [NPORTS*IDX_W-1:0]   grantSrc,
  output logic [NPORTS-1:0]         grantFromBuf,
  output logic [NPORTS*TAG_W-1:0]   grantTag
);
  logic [IDX_W-1:0] nDest [NPORTS];
  logic [IDX_W-1:0] hDest [NPORTS];
  logic [TAG_W-1:0] nTag  [NPORTS];
  logic [TAG_W-1:0] hTag  [NPORTS];

  logic [NPORTS-1:0][NPORTS-1:0] bufHit, newHit, arbReq, gnt, gntBySrc;
  logic [NPORTS-1:0][IDX_W-1:0]  gntIdx;
  logic [NPORTS-1:0]             gntAny, anyBuf, popHit, newWin;

  for (genvar i = 0; i < NPORTS; i++) begin : gUnpack
    assign nDest[i] = newDest[i*IDX_W +: IDX_W];
    assign hDest[i] = headDest[i*IDX_W +: IDX_W];
    assign nTag[i]  = newTag[i*TAG_W +: TAG_W];
    assign hTag[i]  = headTag[i*TAG_W +: TAG_W];
  end

  // Request matrices: [output][source]
  always_comb begin
    for (int o = 0; o < NPORTS; o++) begin
      for (int i = 0; i < NPORTS; i++) begin
        bufHit[o][i] = !bufEmpty[i] && (hDest[i] == IDX_W'(o));
        newHit[o][i] = newValid[i] && bufEmpty[i] && (nDest[i] == IDX_W'(o));
      end
      anyBuf[o] = |bufHit[o];
      arbReq[o] = anyBuf[o] ? bufHit[o] : newHit[o];
    end
  end

  for (genvar o = 0; o < NPORTS; o++) begin : gOut
    spec_rr_arb #(.N(NPORTS)) arb_i (
      .clk(clk), .rstN(rstN), .req(arbReq[o]),
      .gnt(gnt[o]), .gntIdx(gntIdx[o]), .gntAny(gntAny[o])
    );
    assign grantValid[o]                  = gntAny[o];
    assign grantFromBuf[o]                = gntAny[o] && anyBuf[o];
    assign grantSrc[o*IDX_W +: IDX_W]     = gntIdx[o];
    assign grantTag[o*TAG_W +: TAG_W]     = anyBuf[o] ? hTag[gntIdx[o]] : nTag[gntIdx[o]];

    AST_BUF_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      anyBuf[o] |-> ((gnt[o] & bufHit[o]) != '0));  // R3
  end

  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      for (int o = 0; o < NPORTS; o++) gntBySrc[i][o] = gnt[o][i];
      popHit[i] = !bufEmpty[i] && (gntBySrc[i] != '0);
      newWin[i] = bufEmpty[i] && (gntBySrc[i] != '0);
      strobes[i].pop  = popHit[i];
      strobes[i].push = newValid[i] && !newWin[i];
    end
  end

  for (genvar i = 0; i < NPORTS; i++) begin : gSrcChk
    AST_ONE_OUT_PER_SRC: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(gntBySrc[i]));  // R1
    AST_DIVERT: assert property (@(posedge clk) disable iff (!rstN)
      (newValid[i] && !bufEmpty[i]) |-> strobes[i].push);  // R5
  end
endmodule

// File: rtl/spec_out_alloc.sv
module spec_out_alloc #(
  parameter int NPORTS = 4,
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 4,
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NPORTS-1:0]         newValid,
  input  logic [NPORTS*IDX_W-1:0]   newDest,
  input  logic [NPORTS*TAG_W-1:0]   newTag,
  output logic [NPORTS-1:0]         fullFlag,
  output logic [NPORTS-1:0]         grantValid,
  output logic [NPORTS*IDX_W-1:0]   grantSrc,
  output logic [NPORTS-1:0]         grantFromBuf,
  output logic [NPORTS*TAG_W-1:0]   grantTag
);
  spec_alloc_pkg::bufStrobe_t [NPORTS-1:0] strobes;
  logic [NPORTS*IDX_W-1:0] headDest;
  logic [NPORTS*TAG_W-1:0] headTag;
  logic [NPORTS-1:0]       bufEmpty;

  spec_alloc_ctrl #(.NPORTS(NPORTS), .IDX_W(IDX_W), .TAG_W(TAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .newValid(newValid), .newDest(newDest), .newTag(newTag),
    .headDest(headDest), .headTag(headTag), .bufEmpty(bufEmpty), .strobes(strobes),
    .grantValid(grantValid), .grantSrc(grantSrc), .grantFromBuf(grantFromBuf),
    .grantTag(grantTag)
  );

  spec_alloc_buf #(.NPORTS(NPORTS), .DEPTH(DEPTH), .IDX_W(IDX_W), .TAG_W(TAG_W)) buf_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .newDest(newDest), .newTag(newTag),
    .headDest(headDest), .headTag(headTag), .bufEmpty(bufEmpty), .fullFlag(fullFlag)
  );
endmodule

// File: tb/spec_out_alloc_tb_top.sv
module spec_out_alloc_tb_top;
  localparam int NP = 4;
  localparam int IW = 2;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    newValid = '0;
  logic [NP*IW-1:0] newDest = '0;
  logic [NP*TW-1:0] newTag = '0;
  logic [NP-1:0]    fullFlag, grantValid, grantFromBuf;
  logic [NP*IW-1:0] grantSrc;
  logic [NP*TW-1:0] grantTag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spec_out_alloc #(.NPORTS(NP), .DEPTH(4), .TAG_W(TW)) dut_i (
    .clk(clk), .rstN(rstN), .newValid(newValid), .newDest(newDest), .newTag(newTag),
    .fullFlag(fullFlag), .grantValid(grantValid), .grantSrc(grantSrc),
    .grantFromBuf(grantFromBuf), .grantTag(grantTag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {newValid, newDest, expValid, expFromBuf, expSrc}; source/output 3 at the MSB
  localparam logic [27:0] VEC [6] = '{
    {4'b1111, 8'b00111001, 4'b1111, 4'b0000, 8'b10010011},
    {4'b1111, 8'b10101010, 4'b0100, 4'b0000, 8'b00100000},
    {4'b0000, 8'b00000000, 4'b0100, 4'b0100, 8'b00110000},
    {4'b1100, 8'b00100000, 4'b0101, 4'b0100, 8'b00000011},
    {4'b0010, 8'b00000000, 4'b0100, 4'b0100, 8'b00010000},
    {4'b0000, 8'b00000000, 4'b0101, 4'b0101, 8'b00100001}
  };

  // Scoreboard mirroring the contents of each source's buffer
  logic [TW-1:0] qTag  [NP][8];
  logic [IW-1:0] qDest [NP][8];
  int qHead [NP];
  int qCnt  [NP];
  logic [TW-1:0] tagCnt [NP];
  logic [NP-1:0] prevFull;

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; newValid = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NP; i++) begin qHead[i] = 0; qCnt[i] = 0; tagCnt[i] = '0; end
    prevFull = '0;
  endtask

  task automatic stressCycle(input int mode);
    int gCount;
    int gOut;
    @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      newValid[i] = (mode != 2) && !prevFull[i] && ($urandom % 4 != 0);
      newDest[i*IW +: IW] = (mode == 0) ? '0 : IW'($urandom % NP);
      newTag[i*TW +: TW] = tagCnt[i];
    end
    #2;
    // R3: a buffered head targeting an output forces a buffered grant there
    for (int o = 0; o < NP; o++) begin
      bit want;
      want = 1'b0;
      for (int i = 0; i < NP; i++)
        if (qCnt[i] > 0 && qDest[i][qHead[i]] == IW'(o)) want = 1'b1;
      if (want) chk(grantValid[o] && grantFromBuf[o], "R3 buffered wins", int'(grantFromBuf[o]), 1);
    end
    for (int i = 0; i < NP; i++) begin
      chk(fullFlag[i] == (qCnt[i] >= 3), "R7 full flag", int'(fullFlag[i]), int'(qCnt[i] >= 3));
      gCount = 0; gOut = -1;
      for (int o = 0; o < NP; o++)
        if (grantValid[o] && grantSrc[o*IW +: IW] == IW'(i)) begin gCount++; gOut = o; end
      chk(gCount <= 1, "R1 one output per source", gCount, 1);
      if (qCnt[i] > 0) begin
        if (gOut >= 0) begin
          chk(grantFromBuf[gOut] && grantTag[gOut*TW +: TW] == qTag[i][qHead[i]],
              "R6 buffered order", int'(grantTag[gOut*TW +: TW]), int'(qTag[i][qHead[i]]));
          chk(gOut == int'(qDest[i][qHead[i]]), "R4 buffered dest", gOut, int'(qDest[i][qHead[i]]));
          qHead[i] = (qHead[i] + 1) % 8; qCnt[i]--;
        end
        if (newValid[i]) begin
          qTag[i][(qHead[i] + qCnt[i]) % 8] = newTag[i*TW +: TW];
          qDest[i][(qHead[i] + qCnt[i]) % 8] = newDest[i*IW +: IW];
          qCnt[i]++;
        end
      end else begin
        if (gOut >= 0) begin
          chk(newValid[i] && !grantFromBuf[gOut] && grantTag[gOut*TW +: TW] == newTag[i*TW +: TW]
              && gOut == int'(newDest[i*IW +: IW]), "R1 new grant matches request",
              int'(grantTag[gOut*TW +: TW]), int'(newTag[i*TW +: TW]));
        end else if (newValid[i]) begin
          qTag[i][qHead[i]] = newTag[i*TW +: TW];
          qDest[i][qHead[i]] = newDest[i*IW +: IW];
          qCnt[i] = 1;
        end
      end
      chk(qCnt[i] <= 4, "R7 occupancy bound", qCnt[i], 4);
      if (newValid[i]) tagCnt[i] = tagCnt[i] + 1'b1;
      prevFull[i] = fullFlag[i];
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFail);
      $finish;
    end
  end

  initial begin
    doReset();
    #2;
    // R8: reset state
    chk(fullFlag == '0, "R8 full low", int'(fullFlag), 0);
    chk(grantValid == '0, "R8 no grant", int'(grantValid), 0);

    // Table walk: R2 pointer order, R3 buffered priority, R5 diversion, R4 replay
    foreach (VEC[s]) begin
      @(negedge clk);
      newValid = VEC[s][27:24];
      newDest  = VEC[s][23:16];
      newTag   = '0;
      #2;
      chk(grantValid == VEC[s][15:12], "R2 R3 table grantValid", int'(grantValid), int'(VEC[s][15:12]));
      chk(grantFromBuf == VEC[s][11:8], "R3 R5 table grantFromBuf", int'(grantFromBuf), int'(VEC[s][11:8]));
      for (int o = 0; o < NP; o++)
        if (VEC[s][12+o])
          chk(grantSrc[o*IW +: IW] == VEC[s][o*IW +: IW], "R2 table grantSrc",
              int'(grantSrc[o*IW +: IW]), int'(VEC[s][o*IW +: IW]));
    end
    @(negedge clk);
    newValid = '0;
    #2;
    chk(grantValid == '0, "R4 buffers drained", int'(grantValid), 0);

    // Incast, then mixed destinations, then drain
    doReset();
    for (int c = 0; c < 150; c++) stressCycle(0);
    for (int c = 0; c < 300; c++) stressCycle(1);
    for (int c = 0; c < 40; c++)  stressCycle(2);
    for (int i = 0; i < NP; i++) begin
      chk(qCnt[i] == 0, "R4 no packet left behind", qCnt[i], 0);
      chk(fullFlag[i] == 1'b0, "R7 full clears", int'(fullFlag[i]), 0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule